// File: doc/BRIEF.md
# Core module control register bank

This block is a word-addressed bank of board-level control and status registers that sits on a simple single-cycle bus. The byte offset on the bus selects a 32-bit word. Reads are combinational and writes take effect at the clock edge. The bank holds the following:

- Two constant identification words.
- Two oscillator setting registers. Writes to these only take effect while a 16-bit key is loaded.
- A control register. Its bits drive an LED output and a memory-remap output, and one bit requests a system reset.
- A memory configuration word that reflects the installed memory size.
- Two pairs of set/clear flag registers.
- A free-running reference counter.
- A read-only presence-detect byte window.
- A small interrupt group with one software interrupt source. Separate enable masks route that source to a normal and a fast interrupt output.

The reference counter advances on a clock-enable strobe. A divider produces the strobe from the bus clock once every `REF_DIV` cycles, which is chosen to give the fixed reference rate. Voltage control words exist only as placeholders. Any access that does not match a defined register reads zero, changes nothing and raises a one-cycle error pulse.

Top module: `cmctl_regs`

## Requirements
- R1: Word index 0 (byte offset 0x00) reads 0x411A3001, index 4 reads 0x00100000 and index 1 reads zero.
- R2: A write to index 5 stores the low 16 bits of the data. It reads back as 0x0001A05F while the stored key is 0xA05F, and as the stored 16-bit value otherwise.
- R3: Index 2 resets to 0x01000048 and index 7 resets to 0x0007FEFF. A write to either changes it only when the key held before that write is 0xA05F.
- R4: A write to index 3 stores data bits 0 and 2; bit 1 and bit 3 always read zero. `led_on` follows stored bit 0 and `remap_ram` follows stored bit 2. A write with data bit 3 set makes `reset_req` high for the single cycle after that write.
- R5: A write to index 12 ORs the data into the flags and a write to index 13 clears the bits set in the data. Index 12 reads the flags. Indices 14 and 15 act the same way on a separate second flags word, which is read at index 14.
- R6: Writes to index 18 and 26 OR the data into the normal and fast enable masks; writes to 19 and 27 clear the written bits. Index 18 and 26 read the masks, 17 and 25 read the raw level, and 16 and 24 read level AND the respective mask. `irq_out` and `fiq_out` are high when that AND is nonzero.
- R7: The soft interrupt is level bit 0, and all other level bits are zero. It is set by a write to index 20 and cleared by a write to index 21, in both cases only when data bit 0 is 1. Index 20 reads the level bit 0.
- R8: Index 10 reads a 32-bit counter that is zero at reset and increases by exactly one every `REF_DIV` clock cycles.
- R9: Byte offsets 0x100 to 0x17C read, in the low byte, presence-detect entry number offset>>2 (entries 64 to 95). Entries 73 to 83 hold the ASCII text "CORE-MODULE" in order and all other entries are zero. Offsets 0x180 to 0x1FC read zero.
- R10: Index 8 resets to 0x00011122 with a size code ORed into bits [4:2]: 0x10 for `MEM_MB`≥256, 0x0C for ≥128, 0x08 for ≥64, 0x04 for ≥32 and 0 below. Index 9 resets to 0x00000112. Both store any write.
- R11: Indices 32 to 35 read zero, ignore writes and raise no error.
- R12: Readable indices are 0-5, 7-10, 12, 14, 16-18, 20, 24-26 and 32-35, plus the whole 0x100-0x1FC window. Writable indices are 2, 3, 5, 7-9, 12-15, 18-21, 26, 27 and 32-35. Any other access reads zero, changes no state, and sets `acc_err` high for the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| led_on | output | 1 | Control bit 0 |
| remap_ram | output | 1 | Control bit 2: boot flash unmapped from address zero |
| reset_req | output | 1 | One-cycle system reset request |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |
| acc_err | output | 1 | One-cycle flag for an undefined access |

## Verification
The bench builds the block with `MEM_MB`=128 and `REF_DIV`=3. The first gives the distinct size code 0x0C in the memory configuration word. The second is short enough that a 30-cycle window must show exactly ten counter steps. Both ends of the bus map are swept word by word, reading every index and writing every non-writable one. The sweep compares each word and each error flag with values derived from the register list, so decode slips anywhere in the map show up. Directed sequences then cover key gating, the reset pulse, set/clear arithmetic and interrupt routing.

// File: rtl/cmctl_pkg.sv
package cmctl_pkg;

  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] ID_WORD   = 32'h411A_3001;
  localparam logic [DW-1:0] STAT_WORD = 32'h0010_0000;
  localparam logic [15:0]   UNLOCK    = 16'hA05F;
  localparam logic [DW-1:0] OSC_RST   = 32'h0100_0048;
  localparam logic [DW-1:0] AUX_RST   = 32'h0007_FEFF;
  localparam logic [DW-1:0] SDR_BASE  = 32'h0001_1122;
  localparam logic [DW-1:0] INIT_RST  = 32'h0000_0112;

  // word indices of the regular region
  localparam logic [5:0] IX_ID   = 6'd0;
  localparam logic [5:0] IX_PROC = 6'd1;
  localparam logic [5:0] IX_OSC  = 6'd2;
  localparam logic [5:0] IX_CTRL = 6'd3;
  localparam logic [5:0] IX_STAT = 6'd4;
  localparam logic [5:0] IX_KEY  = 6'd5;
  localparam logic [5:0] IX_AUX  = 6'd7;
  localparam logic [5:0] IX_SDR  = 6'd8;
  localparam logic [5:0] IX_INIT = 6'd9;
  localparam logic [5:0] IX_REF  = 6'd10;
  localparam logic [5:0] IX_FLGS = 6'd12;
  localparam logic [5:0] IX_FLGC = 6'd13;
  localparam logic [5:0] IX_NVS  = 6'd14;
  localparam logic [5:0] IX_NVC  = 6'd15;
  localparam logic [5:0] IX_IST  = 6'd16;
  localparam logic [5:0] IX_IRAW = 6'd17;
  localparam logic [5:0] IX_IENS = 6'd18;
  localparam logic [5:0] IX_IENC = 6'd19;
  localparam logic [5:0] IX_SWS  = 6'd20;
  localparam logic [5:0] IX_SWC  = 6'd21;
  localparam logic [5:0] IX_FST  = 6'd24;
  localparam logic [5:0] IX_FRAW = 6'd25;
  localparam logic [5:0] IX_FENS = 6'd26;
  localparam logic [5:0] IX_FENC = 6'd27;
  localparam logic [5:0] IX_V0   = 6'd32;
  localparam logic [5:0] IX_V1   = 6'd33;
  localparam logic [5:0] IX_V2   = 6'd34;
  localparam logic [5:0] IX_V3   = 6'd35;

  typedef struct packed {
    logic ien_set;
    logic ien_clr;
    logic fen_set;
    logic fen_clr;
    logic sw_set;
    logic sw_clr;
  } intc_wr_t;

  function automatic logic rd_ok(input logic [5:0] ix);
    case (ix)
      IX_ID, IX_PROC, IX_OSC, IX_CTRL, IX_STAT, IX_KEY, IX_AUX, IX_SDR,
      IX_INIT, IX_REF, IX_FLGS, IX_NVS, IX_IST, IX_IRAW, IX_IENS, IX_SWS,
      IX_FST, IX_FRAW, IX_FENS, IX_V0, IX_V1, IX_V2, IX_V3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic wr_ok(input logic [5:0] ix);
    case (ix)
      IX_OSC, IX_CTRL, IX_KEY, IX_AUX, IX_SDR, IX_INIT, IX_FLGS, IX_FLGC,
      IX_NVS, IX_NVC, IX_IENS, IX_IENC, IX_SWS, IX_SWC, IX_FENS, IX_FENC,
      IX_V0, IX_V1, IX_V2, IX_V3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] sdram_reset(input int unsigned mb);
    logic [DW-1:0] v;
    v = SDR_BASE;
    if (mb >= 256)     v = v | 32'h10;
    else if (mb >= 128) v = v | 32'h0C;
    else if (mb >= 64)  v = v | 32'h08;
    else if (mb >= 32)  v = v | 32'h04;
    return v;
  endfunction

endpackage

// File: rtl/cmctl_refstrobe.sv
module cmctl_refstrobe #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == CW'(DIV - 1));

      always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (wrap) cnt_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = wrap;

      AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DIV - 1)); // R8
    end
  endgenerate

endmodule

// File: rtl/cmctl_refcount.sv
module cmctl_refcount #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R8

endmodule

// File: rtl/cmctl_spd.sv
module cmctl_spd #(
  parameter logic [87:0]  TAG      = "CORE-MODULE",
  parameter int unsigned  TAG_BASE = 73
) (
  input  logic [6:0] entry,
  output logic [7:0] byte_o
);

  localparam int unsigned TAG_LEN = $bits(TAG) / 8;

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < TAG_LEN; k++) begin
      if (int'(entry) == TAG_BASE + k) byte_o = TAG[8*(TAG_LEN-1-k) +: 8];
    end
  end

endmodule

// File: rtl/cmctl_intc.sv
module cmctl_intc
  import cmctl_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  intc_wr_t     wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] level,
  output logic [W-1:0] irq_en,
  output logic [W-1:0] fiq_en,
  output logic         irq_o,
  output logic         fiq_o
);

  localparam int unsigned NBANK = 2;

  logic [NBANK-1:0] set_v;
  logic [NBANK-1:0] clr_v;
  logic [W-1:0]     en_q [NBANK];
  logic             sw_q;
  logic             sw_d;

  assign set_v = {wr.fen_set, wr.ien_set};
  assign clr_v = {wr.fen_clr, wr.ien_clr};

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [W-1:0] en_d;
      always_comb begin
        en_d = en_q[b];
        if (set_v[b]) en_d = en_q[b] | wdata;
        if (clr_v[b]) en_d = en_q[b] & ~wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q[b] <= '0;
        else        en_q[b] <= en_d;
      end
      AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q[b]) |-> $past(set_v[b] | clr_v[b])); // R6
    end
  endgenerate

  always_comb begin
    sw_d = sw_q;
    if (wr.sw_set && wdata[0])      sw_d = 1'b1;
    else if (wr.sw_clr && wdata[0]) sw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= sw_d;
  end

  assign level  = {{(W-1){1'b0}}, sw_q};
  assign irq_en = en_q[0];
  assign fiq_en = en_q[1];
  assign irq_o  = |(level & en_q[0]);
  assign fiq_o  = |(level & en_q[1]);

  AST_SOFT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_q) |-> $past((wr.sw_set | wr.sw_clr) & wdata[0])); // R7

endmodule

// File: rtl/cmctl_regs.sv
module cmctl_regs
  import cmctl_pkg::*;
#(
  parameter int unsigned MEM_MB  = 128,
  parameter int unsigned REF_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [8:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          led_on,
  output logic          remap_ram,
  output logic          reset_req,
  output logic          irq_out,
  output logic          fiq_out,
  output logic          acc_err
);

  localparam logic [DW-1:0] SDR_RST = sdram_reset(MEM_MB);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  // address decode
  logic       in_win;
  logic [5:0] ix;
  logic       wr_en;
  logic       acc_ok;
  logic       unused_lsb;

  assign in_win     = bus_addr[8];
  assign ix         = bus_addr[7:2];
  assign wr_en      = bus_sel & bus_wr & ~in_win;
  assign unused_lsb = ^bus_addr[1:0];

  always_comb begin
    if (in_win)      acc_ok = ~bus_wr;
    else if (bus_wr) acc_ok = wr_ok(ix);
    else             acc_ok = rd_ok(ix);
  end

  // register state
  logic [DW-1:0] osc_q, osc_d, aux_q, aux_d, sdr_q, sdr_d, init_q, init_d;
  logic [DW-1:0] flg_q, flg_d, nvf_q, nvf_d;
  logic [15:0]   key_q, key_d;
  logic [1:0]    ctrl_q, ctrl_d;
  logic          rreq_q, rreq_d, err_q, err_d;
  logic          key_open;

  assign key_open = (key_q == UNLOCK);

  always_comb begin
    osc_d  = osc_q;
    aux_d  = aux_q;
    sdr_d  = sdr_q;
    init_d = init_q;
    flg_d  = flg_q;
    nvf_d  = nvf_q;
    key_d  = key_q;
    ctrl_d = ctrl_q;
    rreq_d = 1'b0;
    err_d  = bus_sel & ~acc_ok;
    if (wr_en) begin
      case (ix)
        IX_OSC:  if (key_open) osc_d = bus_wdata;
        IX_AUX:  if (key_open) aux_d = bus_wdata;
        IX_KEY:  key_d  = bus_wdata[15:0];
        IX_CTRL: begin
          ctrl_d = {bus_wdata[2], bus_wdata[0]};
          rreq_d = bus_wdata[3];
        end
        IX_SDR:  sdr_d  = bus_wdata;
        IX_INIT: init_d = bus_wdata;
        IX_FLGS: flg_d  = flg_q | bus_wdata;
        IX_FLGC: flg_d  = flg_q & ~bus_wdata;
        IX_NVS:  nvf_d  = nvf_q | bus_wdata;
        IX_NVC:  nvf_d  = nvf_q & ~bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      osc_q  <= OSC_RST;
      aux_q  <= AUX_RST;
      sdr_q  <= SDR_RST;
      init_q <= INIT_RST;
      flg_q  <= '0;
      nvf_q  <= '0;
      key_q  <= '0;
      ctrl_q <= '0;
      rreq_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      osc_q  <= osc_d;
      aux_q  <= aux_d;
      sdr_q  <= sdr_d;
      init_q <= init_d;
      flg_q  <= flg_d;
      nvf_q  <= nvf_d;
      key_q  <= key_d;
      ctrl_q <= ctrl_d;
      rreq_q <= rreq_d;
      err_q  <= err_d;
    end
  end

  // reference counter
  logic          ref_tick;
  logic [DW-1:0] ref_cnt;

  cmctl_refstrobe #(.DIV(REF_DIV)) u_strobe (
    .clk  (clk),
    .rst_n(rst_n_s),
    .tick (ref_tick)
  );

  cmctl_refcount #(.W(DW)) u_refcnt (
    .clk  (clk),
    .rst_n(rst_n_s),
    .tick (ref_tick),
    .count(ref_cnt)
  );

  // interrupt group
  intc_wr_t      iwr;
  logic [DW-1:0] lvl, ien, fen;

  always_comb begin
    iwr.ien_set = wr_en & (ix == IX_IENS);
    iwr.ien_clr = wr_en & (ix == IX_IENC);
    iwr.fen_set = wr_en & (ix == IX_FENS);
    iwr.fen_clr = wr_en & (ix == IX_FENC);
    iwr.sw_set  = wr_en & (ix == IX_SWS);
    iwr.sw_clr  = wr_en & (ix == IX_SWC);
  end

  cmctl_intc #(.W(DW)) u_intc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr    (iwr),
    .wdata (bus_wdata),
    .level (lvl),
    .irq_en(ien),
    .fiq_en(fen),
    .irq_o (irq_out),
    .fiq_o (fiq_out)
  );

  // presence-detect window
  logic [7:0] spd_byte;

  cmctl_spd u_spd (
    .entry (bus_addr[8:2]),
    .byte_o(spd_byte)
  );

  // read path
  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      if (!bus_addr[7]) bus_rdata = {24'b0, spd_byte};
    end else begin
      case (ix)
        IX_ID:   bus_rdata = ID_WORD;
        IX_OSC:  bus_rdata = osc_q;
        IX_CTRL: bus_rdata = {29'b0, ctrl_q[1], 1'b0, ctrl_q[0]};
        IX_STAT: bus_rdata = STAT_WORD;
        IX_KEY:  bus_rdata = {15'b0, key_open, key_q};
        IX_AUX:  bus_rdata = aux_q;
        IX_SDR:  bus_rdata = sdr_q;
        IX_INIT: bus_rdata = init_q;
        IX_REF:  bus_rdata = ref_cnt;
        IX_FLGS: bus_rdata = flg_q;
        IX_NVS:  bus_rdata = nvf_q;
        IX_IST:  bus_rdata = lvl & ien;
        IX_IRAW: bus_rdata = lvl;
        IX_IENS: bus_rdata = ien;
        IX_SWS:  bus_rdata = {31'b0, lvl[0]};
        IX_FST:  bus_rdata = lvl & fen;
        IX_FRAW: bus_rdata = lvl;
        IX_FENS: bus_rdata = fen;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign led_on    = ctrl_q[0];
  assign remap_ram = ctrl_q[1];
  assign reset_req = rreq_q;
  assign acc_err   = err_q;

  AST_OSC_KEYED: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(osc_q) |-> ($past(key_q) == UNLOCK)); // R3
  AST_AUX_KEYED: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(aux_q) |-> ($past(key_q) == UNLOCK)); // R3
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    reset_req |-> $past(bus_sel & bus_wr & bus_wdata[3])); // R4
  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(remap_ram) |-> $past(bus_sel & bus_wr)); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    acc_err |-> $past(bus_sel)); // R12
  AST_KEY_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_addr == 9'h014) |-> (bus_rdata[16] == (bus_rdata[15:0] == UNLOCK))); // R2

endmodule

// File: tb/cmctl_regs_bench.sv
module cmctl_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_MB     = 128;
  localparam int REF_DIV    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        led_on, remap_ram, reset_req, irq_out, fiq_out, acc_err;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmctl_regs #(.MEM_MB(MEM_MB), .REF_DIV(REF_DIV)) u_cmctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_on(led_on), .remap_ram(remap_ram), .reset_req(reset_req),
    .irq_out(irq_out), .fiq_out(fiq_out), .acc_err(acc_err)
  );

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  logic        last_err;
  logic        last_req;

  task automatic wr(input int idx_b, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'(idx_b); bus_wdata = d;
    @(negedge clk);
    last_err = acc_err; last_req = reset_req;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx_b, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 9'(idx_b);
    #1 d = bus_rdata;
    @(negedge clk);
    last_err = acc_err;
    bus_sel = 1'b0;
  endtask

  function automatic bit can_rd(input int i);
    if (i >= 64) return 1'b1;
    case (i)
      0,1,2,3,4,5,7,8,9,10,12,14,16,17,18,20,24,25,26,32,33,34,35: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit can_wr(input int i);
    if (i >= 64) return 1'b0;
    case (i)
      2,3,5,7,8,9,12,13,14,15,18,19,20,21,26,27,32,33,34,35: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] spd_exp(input int e);
    logic [87:0] txt;
    txt = "CORE-MODULE";
    if (e >= 73 && e <= 83) return {24'b0, txt[8*(10-(e-73)) +: 8]};
    return 32'h0;
  endfunction

  function automatic logic [31:0] rst_exp(input int i);
    case (i)
      0: return 32'h411A3001;
      2: return 32'h01000048;
      4: return 32'h00100000;
      7: return 32'h0007FEFF;
      8: return 32'h0001112E;
      9: return 32'h00000112;
      default: ;
    endcase
    if (i >= 64 && i < 96) return spd_exp(i);
    return 32'h0;
  endfunction

  function automatic string req_of(input int i);
    if (i >= 64) return "R9";
    case (i)
      0,1,4: return "R1";
      5: return "R2";
      2,7: return "R3";
      3: return "R4";
      12,14: return "R5";
      16,17,18,24,25,26: return "R6";
      20: return "R7";
      8,9: return "R10";
      32,33,34,35: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic read_sweep();
    logic [31:0] v;
    for (int i = 0; i < 128; i++) begin
      rd(i*4, v);
      if (i != 10) chk($sformatf("%s idx%0d value", req_of(i), i), v, rst_exp(i));
      chk($sformatf("R12 idx%0d read err", i), {31'b0, last_err}, {31'b0, !can_rd(i)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all R) got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state at the pins
    chk("R4 led after reset", {31'b0, led_on}, 32'h0);
    chk("R4 remap after reset", {31'b0, remap_ram}, 32'h0);
    chk("R4 reset_req after reset", {31'b0, reset_req}, 32'h0);
    chk("R6 irq after reset", {31'b0, irq_out}, 32'h0);
    chk("R6 fiq after reset", {31'b0, fiq_out}, 32'h0);
    rd(40, v);
    chk("R8 counter near zero after reset", {31'b0, v < 32'd8}, 32'h1);

    // full map: reset values and read errors (R1, R9, R10, R12)
    read_sweep();

    // writes to every non-writable word: error pulse, no state change (R12)
    for (int i = 0; i < 128; i++) begin
      if (!can_wr(i)) begin
        wr(i*4, 32'hFFFF_FFFF);
        chk($sformatf("R12 idx%0d write err", i), {31'b0, last_err}, 32'h1);
      end
    end
    read_sweep();
    @(negedge clk);
    chk("R12 err pulse ends", {31'b0, acc_err}, 32'h0);

    // key and oscillator gating (R2, R3)
    wr(5*4, 32'h1234_ABCD);
    rd(5*4, v); chk("R2 key low half", v, 32'h0000_ABCD);
    wr(2*4, 32'hDEAD_BEEF);
    rd(2*4, v); chk("R3 osc locked", v, 32'h0100_0048);
    wr(7*4, 32'h1111_2222);
    rd(7*4, v); chk("R3 aux locked", v, 32'h0007_FEFF);
    wr(5*4, 32'hFFFF_A05F);
    rd(5*4, v); chk("R2 key open flag", v, 32'h0001_A05F);
    wr(2*4, 32'h1234_5678);
    rd(2*4, v); chk("R3 osc unlocked", v, 32'h1234_5678);
    wr(7*4, 32'h8765_4321);
    rd(7*4, v); chk("R3 aux unlocked", v, 32'h8765_4321);
    wr(5*4, 32'h0000_A05E);
    wr(2*4, 32'h0);
    rd(2*4, v); chk("R3 osc relocked", v, 32'h1234_5678);

    // control register (R4)
    wr(3*4, 32'hFFFF_FFFF);
    chk("R4 reset_req pulse", {31'b0, last_req}, 32'h1);
    chk("R4 led set", {31'b0, led_on}, 32'h1);
    chk("R4 remap set", {31'b0, remap_ram}, 32'h1);
    @(negedge clk);
    chk("R4 reset_req one cycle", {31'b0, reset_req}, 32'h0);
    rd(3*4, v); chk("R4 ctrl readback", v, 32'h5);
    wr(3*4, 32'h4);
    chk("R4 no req without bit3", {31'b0, last_req}, 32'h0);
    chk("R4 led clear", {31'b0, led_on}, 32'h0);
    chk("R4 remap kept", {31'b0, remap_ram}, 32'h1);
    wr(3*4, 32'h8);
    chk("R4 req with bit3 only", {31'b0, last_req}, 32'h1);
    chk("R4 remap clear", {31'b0, remap_ram}, 32'h0);

    // flags (R5)
    wr(12*4, 32'hF0F0_0000);
    wr(12*4, 32'h0F00_0001);
    rd(12*4, v); chk("R5 flags or", v, 32'hFFF0_0001);
    wr(13*4, 32'h00F0_0001);
    rd(12*4, v); chk("R5 flags clear", v, 32'hFF00_0000);
    wr(14*4, 32'h0000_00A5);
    rd(14*4, v); chk("R5 nvflags set", v, 32'h0000_00A5);
    rd(12*4, v); chk("R5 flags independent", v, 32'hFF00_0000);
    wr(15*4, 32'h0000_0081);
    rd(14*4, v); chk("R5 nvflags clear", v, 32'h0000_0024);

    // interrupts (R6, R7)
    wr(20*4, 32'h2);
    rd(17*4, v); chk("R7 bit1 does not set", v, 32'h0);
    wr(20*4, 32'h1);
    rd(17*4, v); chk("R7 raw level", v, 32'h1);
    rd(25*4, v); chk("R6 fiq raw level", v, 32'h1);
    rd(20*4, v); chk("R7 soft readback", v, 32'h1);
    rd(16*4, v); chk("R6 status masked", v, 32'h0);
    chk("R6 irq masked", {31'b0, irq_out}, 32'h0);
    wr(18*4, 32'hFFFF_0001);
    rd(18*4, v); chk("R6 irq mask", v, 32'hFFFF_0001);
    rd(16*4, v); chk("R6 irq status", v, 32'h1);
    chk("R6 irq out", {31'b0, irq_out}, 32'h1);
    chk("R6 fiq still low", {31'b0, fiq_out}, 32'h0);
    wr(26*4, 32'h1);
    chk("R6 fiq out", {31'b0, fiq_out}, 32'h1);
    rd(24*4, v); chk("R6 fiq status", v, 32'h1);
    wr(19*4, 32'h0000_0001);
    rd(18*4, v); chk("R6 irq mask cleared", v, 32'hFFFF_0000);
    chk("R6 irq out cleared", {31'b0, irq_out}, 32'h0);
    wr(21*4, 32'hFFFF_FFFE);
    rd(20*4, v); chk("R7 clear needs bit0", v, 32'h1);
    wr(21*4, 32'h1);
    rd(20*4, v); chk("R7 soft cleared", v, 32'h0);
    chk("R7 fiq drops", {31'b0, fiq_out}, 32'h0);
    wr(27*4, 32'h1);
    rd(26*4, v); chk("R6 fiq mask cleared", v, 32'h0);

    // reference counter (R8)
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 9'(10*4);
    #1 a = bus_rdata;
    repeat (30) @(negedge clk);
    #1 b = bus_rdata;
    bus_sel = 1'b0;
    chk("R8 ten steps in 30 cycles", b - a, 32'd10);

    // memory words and voltage words (R10, R11)
    wr(8*4, 32'hCAFE_0001);
    rd(8*4, v); chk("R10 sdram write", v, 32'hCAFE_0001);
    wr(9*4, 32'h0000_0ABC);
    rd(9*4, v); chk("R10 init write", v, 32'h0000_0ABC);
    for (int i = 32; i < 36; i++) begin
      wr(i*4, 32'hFFFF_FFFF);
      chk($sformatf("R11 idx%0d write no err", i), {31'b0, last_err}, 32'h0);
      rd(i*4, v);
      chk($sformatf("R11 idx%0d reads zero", i), v, 32'h0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule